// File: doc/BRIEF.md
# Mode-Change Mute and Settle Sequencer

This block governs converter muting around a reconfiguration window of an audio codec. While the mode-change enable input is high, both playback channels are forced to mute whatever the user mute bits say. When the enable drops, the block opens a settle window of a fixed number of sample periods. During that window both playback channels stay muted, the capture path is told to deliver midscale samples, and a calibration-busy status output is held high. Converters keep running during the window, so playback samples are still consumed while the outputs are silent.

The window length is counted in sample ticks only. The busy status falls on the clock edge that samples the final tick, and from then on each playback mute follows its own user mute bit. There is no calibration-request input, so every exit from the mode-change state opens a window. If mode-change enable rises again before the window ends, the window is abandoned at once and the enable alone keeps the playback muted.

Top module: `mcw_settle_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cal_busy and cap_midscale are 0 and pb_mute_l/pb_mute_r equal usr_mute_l/usr_mute_r.
- R2: While mode_chg_en is 1, pb_mute_l and pb_mute_r are both 1 whatever the user mute bits are.
- R3: A high-to-low change of mode_chg_en, sampled on consecutive clock edges, sets cal_busy and cap_midscale from the next clock edge.
- R4: The window lasts exactly SETTLE_PERIODS (default 128) sample ticks: cal_busy stays 1 after the 127th tick and falls at the clock edge that samples the 128th.
- R5: Clock cycles without smp_tick do not advance the window, and smp_tick outside a window has no effect on any output.
- R6: While cal_busy is 1, pb_mute_l, pb_mute_r and cap_midscale are all 1; cap_midscale is 1 only inside a window.
- R7: After the window ends with mode_chg_en at 0, pb_mute_l follows usr_mute_l and pb_mute_r follows usr_mute_r independently.
- R8: If mode_chg_en is 1 at a clock edge while a window is open, cal_busy and cap_midscale are 0 after that edge.
- R9: Every exit from mode-change opens a full window, including an exit that follows a cancelled window.
- R10: A smp_tick in the same cycle as the exit is not counted toward the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_chg_en | input | 1 | Mode-change enable level |
| usr_mute_l | input | 1 | Left user playback mute |
| usr_mute_r | input | 1 | Right user playback mute |
| smp_tick | input | 1 | One-cycle pulse per sample period |
| pb_mute_l | output | 1 | Left playback mute |
| pb_mute_r | output | 1 | Right playback mute |
| cap_midscale | output | 1 | Capture path forced to midscale |
| cal_busy | output | 1 | Calibration-in-progress status |

## Verification
Two functions can meet in one cycle. The first is the exit detection, which loads the window. The second is the tick counting, which shortens it. The bench drives smp_tick in the very cycle mode_chg_en falls and confirms that 128 further ticks, not 127, are needed before cal_busy drops. Cancellation and counting can also coincide: the bench raises mode_chg_en in an open window and expects cal_busy low after that edge. It then lowers the enable again and expects a fresh full window.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  // default settle window, in sample periods
  localparam int unsigned MCW_SETTLE_DEFAULT = 128;

  typedef struct packed {
    logic busy;
    logic midscale;
  } mcw_win_t;
endpackage

// File: rtl/mcw_rst_sync.sv
module mcw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mcw_exit_detect.sv
module mcw_exit_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic mce_in,
  output logic exit_pulse
);
  logic mce_q, mce_d;

  always_comb mce_d = mce_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mce_q <= 1'b0;
    else        mce_q <= mce_d;
  end

  assign exit_pulse = mce_q & ~mce_in;
endmodule

// File: rtl/mcw_settle_cnt.sv
module mcw_settle_cnt
  import mcw_pkg::*;
#(
  parameter int unsigned SETTLE_PERIODS = MCW_SETTLE_DEFAULT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     cancel,
  input  logic     tick,
  output mcw_win_t win
);
  localparam int unsigned CNT_W = $clog2(SETTLE_PERIODS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_PERIODS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign cnt_en = cancel | start | (busy_q & tick);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (cancel) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (start) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      cnt_d = cnt_q - LAST_VAL;
      if (cnt_q == LAST_VAL) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign win.busy     = busy_q;
  assign win.midscale = busy_q;

  // R3
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && (cnt_q == LOAD_VAL));
  // R5
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !start && !cancel) |=> busy_q && $stable(cnt_q));
  // R4
  last_tick_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && !cancel && cnt_q == LAST_VAL) |=> !busy_q);
  // R8
  cancel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy_q);
endmodule

// File: rtl/mcw_mute_mux.sv
module mcw_mute_mux
  import mcw_pkg::*;
(
  input  logic     force_mce,
  input  mcw_win_t win,
  input  logic     usr_l,
  input  logic     usr_r,
  output logic     mute_l,
  output logic     mute_r,
  output logic     midscale
);
  logic force_all;

  always_comb begin
    force_all = force_mce | win.busy;
    mute_l    = force_all | usr_l;
    mute_r    = force_all | usr_r;
    midscale  = win.midscale;
  end
endmodule

// File: rtl/mcw_settle_seq.sv
module mcw_settle_seq
  import mcw_pkg::*;
#(
  parameter int unsigned SETTLE_PERIODS = MCW_SETTLE_DEFAULT,
  parameter int unsigned RST_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chg_en,
  input  logic usr_mute_l,
  input  logic usr_mute_r,
  input  logic smp_tick,
  output logic pb_mute_l,
  output logic pb_mute_r,
  output logic cap_midscale,
  output logic cal_busy
);
  logic     rst_n_int;
  logic     exit_pulse;
  mcw_win_t win;

  mcw_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  mcw_exit_detect u_exit (
    .clk(clk), .rst_n(rst_n_int), .mce_in(mode_chg_en), .exit_pulse(exit_pulse)
  );

  mcw_settle_cnt #(.SETTLE_PERIODS(SETTLE_PERIODS)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .start(exit_pulse), .cancel(mode_chg_en),
    .tick(smp_tick), .win(win)
  );

  mcw_mute_mux u_mux (
    .force_mce(mode_chg_en), .win(win), .usr_l(usr_mute_l), .usr_r(usr_mute_r),
    .mute_l(pb_mute_l), .mute_r(pb_mute_r), .midscale(cap_midscale)
  );

  assign cal_busy = win.busy;

  // R6
  window_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    cal_busy |-> (pb_mute_l && pb_mute_r && cap_midscale));
  // R3
  fall_opens_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(mode_chg_en) && !mode_chg_en) |=> cal_busy);
  // R7
  follow_user_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!cal_busy && !mode_chg_en) |-> (pb_mute_l == usr_mute_l && pb_mute_r == usr_mute_r));
endmodule

// File: tb/mcw_settle_seq_bench.sv
module mcw_settle_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mce = 1'b0, ul = 1'b0, ur = 1'b0, tick = 1'b0;
  logic pl, pr, cm, cb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcw_settle_seq u_mcw_settle_seq (
    .clk(clk), .rst_n(rst_n), .mode_chg_en(mce), .usr_mute_l(ul),
    .usr_mute_r(ur), .smp_tick(tick), .pb_mute_l(pl), .pb_mute_r(pr),
    .cap_midscale(cm), .cal_busy(cb)
  );

  // entry: {mce, ul, ur, tick, exp_pl, exp_pr, exp_busy}
  localparam logic [6:0] VEC [12] = '{
    7'b0000_000, 7'b0101_100, 7'b0010_010, 7'b0111_110,
    7'b1000_110, 7'b1101_110, 7'b1011_110, 7'b0000_111,
    7'b0100_111, 7'b1000_110, 7'b0010_111, 7'b1000_110
  };

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {pl,pr,cm,cb}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(logic m, logic l, logic r, logic t);
    @(negedge clk);
    mce = m; ul = l; ur = r; tick = t;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] ex(logic l, logic r, logic b);
    return {l, r, b, b};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    ul = 1'b1; ur = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", {pl, pr, cm, cb}, ex(1, 0, 0));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cyc(0, 1, 0, 0);
    chk("R1 after reset", {pl, pr, cm, cb}, ex(1, 0, 0));

    // table walk: R2 R3 R5 R6 R7 R8 R9
    foreach (VEC[i]) begin
      cyc(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R2/R3/R5/R6/R7/R8/R9 vec %0d", i), {pl, pr, cm, cb},
          {VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][0]});
    end

    // R4/R5/R7: full window with a gap cycle before each tick, user bits 1/0
    cyc(0, 1, 0, 0);
    chk("R3 exit opens window", {pl, pr, cm, cb}, ex(1, 1, 1));
    for (int k = 1; k <= 128; k++) begin
      cyc(0, 1, 0, 0);
      if (k == 64) chk("R5 idle cycle holds window", {pl, pr, cm, cb}, ex(1, 1, 1));
      cyc(0, 1, 0, 1);
      if (k == 127) chk("R4 open after 127 ticks", {pl, pr, cm, cb}, ex(1, 1, 1));
      if (k == 128) chk("R4 closed at 128th tick", {pl, pr, cm, cb}, ex(1, 0, 0));
    end
    cyc(0, 0, 1, 0);
    chk("R7 follows user after window", {pl, pr, cm, cb}, ex(0, 1, 0));
    cyc(0, 0, 1, 1);
    chk("R5 tick outside window", {pl, pr, cm, cb}, ex(0, 1, 0));

    // R10: tick in exit cycle is not counted
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R10 exit with tick opens", {pl, pr, cm, cb}, ex(1, 1, 1));
    for (int k = 1; k <= 128; k++) begin
      cyc(0, 0, 0, 1);
      if (k == 127) chk("R10 still open after 127 more", {pl, pr, cm, cb}, ex(1, 1, 1));
      if (k == 128) chk("R10 closed after 128 more", {pl, pr, cm, cb}, ex(0, 0, 0));
    end

    // R8/R9: cancel with a tick, then reopen full
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    repeat (50) cyc(0, 0, 0, 1);
    cyc(1, 0, 1, 1);
    chk("R8 cancel with coincident tick", {pl, pr, cm, cb}, ex(1, 1, 0));
    cyc(0, 0, 1, 0);
    for (int k = 1; k <= 128; k++) begin
      cyc(0, 0, 1, 1);
      if (k == 127) chk("R9 reopened window full length", {pl, pr, cm, cb}, ex(1, 1, 1));
    end
    chk("R9 reopened window closes", {pl, pr, cm, cb}, ex(0, 1, 0));

    // R1: reset mid-window
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    repeat (5) cyc(0, 0, 0, 1);
    @(negedge clk); rst_n = 1'b0; ul = 1'b1; ur = 1'b1;
    #1 chk("R1 async reset clears window", {pl, pr, cm, cb}, ex(1, 1, 0));
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule